// File: doc/BRIEF.md
# Two-Pin PWM Generator with GPIO Fallback

This block owns two extended I/O pins. A single mode input decides whether both pins behave as plain general-purpose I/O or as outputs of two independent pulse-width modulators. In GPIO operation each pin has a direction bit and a write bit. The level seen on each pin can be read back: a synchronised pad level for inputs, the driven value for outputs.

In PWM operation each channel builds its waveform from two separately prescaled time bases. A high-time base runs in steps of 5, 10, 20 or 40 us, and a period base runs in steps of 40, 80, 160 or 320 us. Both are derived from one 5 us clock-enable pulse that is counted down from the system clock. An 8-bit count on each base sets the high time and the period.

Configuration is captured into a shadow copy only when a period starts. Changing the inputs at any other time therefore never cuts a pulse short or stretches it. Pad tristate cells and the register bus sit outside the block: it presents an output value, an output enable and a read value per pin.

Top module: `xio_pwm_gpio`

## Requirements
- R1: With `pwm_en` = 1 both pins are outputs (`pad_oe` = 2'b11) and `pad_out[c]` carries the waveform of channel c. With `pwm_en` = 0 the pins follow the GPIO rules of R2, and the PWM configuration has no effect on the pins.
- R2: In GPIO mode, `io_dir[i]` = 1 makes pin i an output (`pad_oe[i]` = 1, `pad_out[i]` = `io_wr[i]`). `io_dir[i]` = 0 makes it an input (`pad_oe[i]` = 0, `pad_out[i]` = 0).
- R3: `io_rd[i]` equals `pad_out[i]` when pin i is an output. When pin i is an input, `io_rd[i]` equals `pad_in[i]` as sampled SYNC_N (default 2) rising edges earlier.
- R4: A base tick occurs every D = CLK_HZ/200000 clock cycles (5 us), first at the D-th rising edge after reset is released. Both channels start their first period on that tick.
- R5: High-tick select field `hi_unit[2c+1:2c]` with value 0, 1, 2, 3 gives a high tick of 1, 2, 4, 8 base ticks (5, 10, 20, 40 us).
- R6: Period-tick select field `per_unit[2c+1:2c]` with value 0, 1, 2, 3 gives a period tick of 8, 16, 32, 64 base ticks (40, 80, 160, 320 us).
- R7: Within each period the waveform is high from the period start for `hi_count[8c+7:8c]` high ticks and then low until `per_count[8c+7:8c]` period ticks have elapsed. A period count of 0 is taken as 256.
- R8: A high count of 0 gives a constant low waveform.
- R9: A high time equal to or longer than the period gives a constant high waveform.
- R10: Configuration inputs are taken in only at a period start. A change inside a period leaves the rest of that period unchanged and applies from the next period start.
- R11: The two channels run independently, each from its own configuration fields.
- R12: From reset until the first base tick both PWM waveforms are low, and the input synchronisers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_en | input | 1 | Pin mode: 0 GPIO, 1 PWM |
| io_dir | input | 2 | GPIO direction per pin, 1 = output |
| io_wr | input | 2 | GPIO output value per pin |
| pad_in | input | 2 | Level arriving from the pads |
| hi_count | input | 16 | High-tick count, channel c in bits 8c+7:8c |
| per_count | input | 16 | Period-tick count, channel c in bits 8c+7:8c |
| hi_unit | input | 4 | High-tick select, channel c in bits 2c+1:2c |
| per_unit | input | 4 | Period-tick select, channel c in bits 2c+1:2c |
| pad_out | output | 2 | Value driven toward the pads |
| pad_oe | output | 2 | Output enable per pad |
| io_rd | output | 2 | Readable pin level per pin |

## Verification
The assertions assume that CLK_HZ is at least 200000, so that the base tick divider is at least one cycle, and that reset is held for at least one edge before the first checked cycle. Under that assumption the waveforms may change only on the cycle after a base tick, and the pin drive relations hold in every cycle. The bench keeps to these conditions: it uses a small clock-rate parameter that gives a three-cycle base tick, holds reset for two edges, and changes every input only on falling edges. Configuration changes made during a run are placed inside a period, so the shadow-capture point is exercised rather than side-stepped.

// File: rtl/xpwm_pkg.sv
package xpwm_pkg;

    localparam int CH_N         = 2;
    localparam int CNT_W        = 8;
    localparam int SEL_W        = 2;
    localparam int HI_BASE_LOG  = 0;
    localparam int PER_BASE_LOG = 3;
    localparam int BASE_TICK_HZ = 200_000;

    localparam int SEL_MAX_SH = (1 << SEL_W) - 1;
    localparam int HI_PRE_W   = (HI_BASE_LOG + SEL_MAX_SH) > 0 ? HI_BASE_LOG + SEL_MAX_SH : 1;
    localparam int PER_PRE_W  = (PER_BASE_LOG + SEL_MAX_SH) > 0 ? PER_BASE_LOG + SEL_MAX_SH : 1;

    localparam logic [CNT_W-1:0]     CNT_ONE = 1;
    localparam logic [HI_PRE_W-1:0]  HI_ONE  = 1;
    localparam logic [PER_PRE_W-1:0] PER_ONE = 1;

    typedef enum logic {
        MODE_GPIO = 1'b0,
        MODE_PWM  = 1'b1
    } io_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] hi_cnt;
        logic [CNT_W-1:0] per_cnt;
        logic [SEL_W-1:0] hi_sel;
        logic [SEL_W-1:0] per_sel;
    } chan_cfg_t;

    typedef struct packed {
        logic                 run;
        logic [PER_PRE_W-1:0] per_pre;
        logic [CNT_W-1:0]     per_tk;
        logic [HI_PRE_W-1:0]  hi_pre;
        logic [CNT_W-1:0]     hi_tk;
    } chan_state_t;

    function automatic logic [HI_PRE_W-1:0] hi_lim(input logic [SEL_W-1:0] s);
        logic [31:0] v;
        v = (32'd1 << (HI_BASE_LOG + int'(s))) - 32'd1;
        return v[HI_PRE_W-1:0];
    endfunction

    function automatic logic [PER_PRE_W-1:0] per_lim(input logic [SEL_W-1:0] s);
        logic [31:0] v;
        v = (32'd1 << (PER_BASE_LOG + int'(s))) - 32'd1;
        return v[PER_PRE_W-1:0];
    endfunction

endpackage

// File: rtl/xpwm_base_tick.sv
module xpwm_base_tick
    import xpwm_pkg::*;
#(
    parameter int CLK_HZ = 200_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DIV = (CLK_HZ / BASE_TICK_HZ) > 0 ? CLK_HZ / BASE_TICK_HZ : 1;
    localparam int W   = DIV > 1 ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam logic [W-1:0] LAST = W'(DIV - 1);
            localparam logic [W-1:0] STEP = 1;
            logic [W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst)               cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                   cnt_q <= cnt_q + STEP;
            end
            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/xpwm_chan.sv
module xpwm_chan
    import xpwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  chan_cfg_t cfg_in,
    output logic      wave
);
    chan_cfg_t   sh_q, sh_d;
    chan_state_t st_q, st_d;
    logic        per_wrap, hi_wrap, hi_done, period_end;

    always_comb begin
        per_wrap   = (st_q.per_pre == per_lim(sh_q.per_sel));
        hi_wrap    = (st_q.hi_pre == hi_lim(sh_q.hi_sel));
        hi_done    = (st_q.hi_tk == sh_q.hi_cnt);
        period_end = per_wrap && (st_q.per_tk == (sh_q.per_cnt - CNT_ONE));
        sh_d = sh_q;
        st_d = st_q;
        if (tick) begin
            if (!st_q.run || period_end) begin
                // period boundary: take new settings, restart both time bases
                sh_d     = cfg_in;
                st_d     = '0;
                st_d.run = 1'b1;
            end else begin
                st_d.per_pre = per_wrap ? '0 : st_q.per_pre + PER_ONE;
                if (per_wrap) st_d.per_tk = st_q.per_tk + CNT_ONE;
                if (!hi_done) begin
                    st_d.hi_pre = hi_wrap ? '0 : st_q.hi_pre + HI_ONE;
                    if (hi_wrap) st_d.hi_tk = st_q.hi_tk + CNT_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            st_q <= '0;
        end else begin
            sh_q <= sh_d;
            st_q <= st_d;
        end
    end

    assign wave = st_q.run && !hi_done;
endmodule

// File: rtl/xpwm_pad.sv
module xpwm_pad
    import xpwm_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  io_mode_e        mode,
    input  logic [CH_N-1:0] dir,
    input  logic [CH_N-1:0] wr,
    input  logic [CH_N-1:0] pad_in,
    input  logic [CH_N-1:0] wave,
    output logic [CH_N-1:0] pad_out,
    output logic [CH_N-1:0] pad_oe,
    output logic [CH_N-1:0] rd
);
    logic [CH_N-1:0] sync_q [SYNC_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_N; s++) sync_q[s] <= '0;
        end else begin
            sync_q[0] <= pad_in;
            for (int s = 1; s < SYNC_N; s++) sync_q[s] <= sync_q[s-1];
        end
    end

    always_comb begin
        if (mode == MODE_PWM) begin
            pad_oe  = '1;
            pad_out = wave;
        end else begin
            pad_oe  = dir;
            pad_out = wr & dir;
        end
        rd = (pad_oe & pad_out) | (~pad_oe & sync_q[SYNC_N-1]);
    end
endmodule

// File: rtl/xio_pwm_gpio.sv
module xio_pwm_gpio
    import xpwm_pkg::*;
#(
    parameter int CLK_HZ = 200_000_000,
    parameter int SYNC_N = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwm_en,
    input  logic [CH_N-1:0]       io_dir,
    input  logic [CH_N-1:0]       io_wr,
    input  logic [CH_N-1:0]       pad_in,
    input  logic [CH_N*CNT_W-1:0] hi_count,
    input  logic [CH_N*CNT_W-1:0] per_count,
    input  logic [CH_N*SEL_W-1:0] hi_unit,
    input  logic [CH_N*SEL_W-1:0] per_unit,
    output logic [CH_N-1:0]       pad_out,
    output logic [CH_N-1:0]       pad_oe,
    output logic [CH_N-1:0]       io_rd
);
    logic            base_tick;
    logic [CH_N-1:0] wave;
    io_mode_e        mode;

    assign mode = pwm_en ? MODE_PWM : MODE_GPIO;

    xpwm_base_tick #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (base_tick)
    );

    generate
        for (genvar c = 0; c < CH_N; c++) begin : g_ch
            chan_cfg_t cfg;
            assign cfg.hi_cnt  = hi_count[c*CNT_W +: CNT_W];
            assign cfg.per_cnt = per_count[c*CNT_W +: CNT_W];
            assign cfg.hi_sel  = hi_unit[c*SEL_W +: SEL_W];
            assign cfg.per_sel = per_unit[c*SEL_W +: SEL_W];
            xpwm_chan u_ch (
                .clk    (clk),
                .rst    (rst),
                .tick   (base_tick),
                .cfg_in (cfg),
                .wave   (wave[c])
            );
        end
    endgenerate

    xpwm_pad #(.SYNC_N(SYNC_N)) u_pad (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .dir     (io_dir),
        .wr      (io_wr),
        .pad_in  (pad_in),
        .wave    (wave),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .rd      (io_rd)
    );
endmodule

// File: rtl/xio_pwm_gpio_chk.sv
module xio_pwm_gpio_chk
    import xpwm_pkg::*;
#(
    parameter int CLK_HZ = 200_000_000
) (
    input logic            clk,
    input logic            rst,
    input logic            base_tick,
    input logic [CH_N-1:0] wave,
    input logic            pwm_en,
    input logic [CH_N-1:0] io_dir,
    input logic [CH_N-1:0] io_wr,
    input logic [CH_N-1:0] pad_out,
    input logic [CH_N-1:0] pad_oe,
    input logic [CH_N-1:0] io_rd
);
    localparam int DIV = (CLK_HZ / BASE_TICK_HZ) > 0 ? CLK_HZ / BASE_TICK_HZ : 1;

    logic [31:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst || base_tick) gap_q <= '0;
        else                  gap_q <= gap_q + 32'd1;
    end

    // R4: base tick spacing, tracked by a counter rather than a long $past
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        base_tick == (gap_q == 32'(DIV - 1)));

    // R7: waveforms move only on the cycle after a base tick
    p_wave_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(base_tick) |-> $stable(wave));

    p_pwm_drive_r1: assert property (@(posedge clk) disable iff (rst)
        pwm_en |-> (pad_oe == '1) && (pad_out == wave));

    p_gpio_drive_r2: assert property (@(posedge clk) disable iff (rst)
        !pwm_en |-> (pad_oe == io_dir) && (pad_out == (io_wr & io_dir)));

    p_read_loop_r3: assert property (@(posedge clk) disable iff (rst)
        ((io_rd ^ pad_out) & pad_oe) == '0);
endmodule

bind xio_pwm_gpio xio_pwm_gpio_chk #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .base_tick (base_tick),
    .wave      (wave),
    .pwm_en    (pwm_en),
    .io_dir    (io_dir),
    .io_wr     (io_wr),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .io_rd     (io_rd)
);

// File: tb/test_xio_pwm_gpio.sv
`timescale 1ns/1ps
module test_xio_pwm_gpio;
    localparam int CLK_HZ = 600_000;
    localparam int D      = CLK_HZ / 200_000;
    localparam int WD_MAX = 190_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwm_en = 1'b0;
    logic [1:0]  io_dir = '0, io_wr = '0, pad_in = '0;
    logic [15:0] hi_count = '0, per_count = '0;
    logic [3:0]  hi_unit = '0, per_unit = '0;
    logic [1:0]  pad_out, pad_oe, io_rd;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;
    int in_hi[2], in_per[2], in_hs[2], in_ps[2];
    int nx_hi[2], nx_per[2], nx_hs[2], nx_ps[2];

    always #2.5 clk = ~clk;

    xio_pwm_gpio #(.CLK_HZ(CLK_HZ)) i_xio_pwm_gpio (
        .clk(clk), .rst(rst), .pwm_en(pwm_en), .io_dir(io_dir), .io_wr(io_wr),
        .pad_in(pad_in), .hi_count(hi_count), .per_count(per_count),
        .hi_unit(hi_unit), .per_unit(per_unit),
        .pad_out(pad_out), .pad_oe(pad_oe), .io_rd(io_rd)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_MAX && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R4 watchdog: cycles %0d expected below %0d", cyc, WD_MAX);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic apply_cfg();
        hi_count  = {8'(in_hi[1]), 8'(in_hi[0])};
        per_count = {8'(in_per[1]), 8'(in_per[0])};
        hi_unit   = {2'(in_hs[1]), 2'(in_hs[0])};
        per_unit  = {2'(in_ps[1]), 2'(in_ps[0])};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int per_base(input int per, input int ps);
        return ((per == 0) ? 256 : per) * (8 << ps);
    endfunction

    // run both channels from reset; at negedge tchg switch to the nx_* set
    task automatic run_pwm(input int ncyc, input int tchg, input string force_tag);
        int st[2], c_hi[2], c_per[2], c_hs[2], c_ps[2];
        bit started = 1'b0;
        pwm_en = 1'b1;
        apply_cfg();
        do_reset();
        for (int t = 1; t <= ncyc; t++) begin
            @(posedge clk);
            if (t % D == 0) begin
                for (int c = 0; c < 2; c++) begin
                    if (!started || (t - st[c]) == per_base(c_per[c], c_ps[c]) * D) begin
                        st[c] = t; c_hi[c] = in_hi[c]; c_per[c] = in_per[c];
                        c_hs[c] = in_hs[c]; c_ps[c] = in_ps[c];
                    end
                end
                started = 1'b1;
            end
            @(negedge clk);
            for (int c = 0; c < 2; c++) begin
                int h, p, e;
                string tag;
                h = c_hi[c] << c_hs[c];
                p = per_base(c_per[c], c_ps[c]);
                e = (started && c_hi[c] != 0 && ((t - st[c]) / D) < h) ? 1 : 0;
                if (force_tag != "")   tag = force_tag;
                else if (!started)     tag = "R12 before first tick";
                else if (t == D)       tag = "R4 first tick";
                else if (c_hi[c] == 0) tag = "R8 zero high";
                else if (h >= p)       tag = "R9 full high";
                else if (c == 1)       tag = "R11 channel 1 R7";
                else                   tag = "R7 R5 R6 waveform";
                chk(tag, int'(pad_out[c]), e);
            end
            if (t == tchg) begin
                in_hi = nx_hi; in_per = nx_per; in_hs = nx_hs; in_ps = nx_ps;
                apply_cfg();
            end
        end
        chk("R1 pwm drive enable", int'(pad_oe), 3);
    endtask

    initial begin
        // reset state
        pwm_en = 1'b1;
        in_hi = '{5, 5}; in_per = '{1, 1}; in_hs = '{0, 0}; in_ps = '{0, 0};
        apply_cfg();
        do_reset();
        chk("R12 reset waveform", int'(pad_out), 0);
        chk("R12 reset read", int'(io_rd), 0);

        // sweep of tick selects, counts, both channels with mirrored selects
        for (int ps = 0; ps < 4; ps++)
            for (int hs = 0; hs < 4; hs++)
                for (int pi = 0; pi < 2; pi++)
                    for (int hi = 0; hi < 4; hi++) begin
                        int hv, pv, pmax;
                        hv = (hi == 0) ? 0 : (hi == 1) ? 1 : (hi == 2) ? 3 : 12;
                        pv = (pi == 0) ? 1 : 3;
                        in_hi  = '{hv, hv + 2};
                        in_per = '{pv, 4 - pv};
                        in_hs  = '{hs, 3 - hs};
                        in_ps  = '{ps, 3 - ps};
                        pmax = per_base(in_per[0], in_ps[0]);
                        if (per_base(in_per[1], in_ps[1]) > pmax) pmax = per_base(in_per[1], in_ps[1]);
                        run_pwm(D + 2 * pmax * D + 2, -1, "");
                    end

        // R10: change inside first period, applied only at next boundary
        in_hi = '{2, 2}; in_per = '{2, 2}; in_hs = '{0, 0}; in_ps = '{0, 0};
        nx_hi = '{10, 0}; nx_per = '{1, 1}; nx_hs = '{0, 0}; nx_ps = '{1, 1};
        run_pwm(D + 16 * D * 3, D * 4, "R10 shadow capture");

        // GPIO mode: exhaustive direction, write value and pad level
        pwm_en = 1'b0;
        in_hi = '{200, 200}; in_per = '{1, 1}; in_hs = '{3, 3}; in_ps = '{0, 0};
        apply_cfg();
        do_reset();
        for (int d = 0; d < 4; d++)
            for (int w = 0; w < 4; w++)
                for (int p = 0; p < 4; p++) begin
                    @(negedge clk);
                    io_dir = 2'(d); io_wr = 2'(w); pad_in = 2'(p);
                    repeat (3) @(negedge clk);
                    chk("R2 R1 gpio enable", int'(pad_oe), d);
                    chk("R2 gpio value", int'(pad_out), d & w);
                    chk("R3 read value", int'(io_rd), (d & w) | (~d & p & 3));
                end

        // R3 synchroniser latency
        io_dir = 2'b00; pad_in = 2'b00;
        repeat (3) @(negedge clk);
        pad_in = 2'b11;
        @(negedge clk);
        chk("R3 one edge old level", int'(io_rd), 0);
        @(negedge clk);
        chk("R3 two edges new level", int'(io_rd), 3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule